// File: doc/BRIEF.md
# Protection-Unit Error Status Register

This block holds the error and interrupt status of a memory protection unit's register interface. It watches every register access on a simple single-cycle read/write port. It raises sticky flags for violations that it detects itself: an access to the control register while a lock is in force, an unaligned address, and a write to a read-only register. It also raises flags for bus errors reported by the protection checks outside it. On every error event it raises an interrupt-request flag, and it records an overrun when a second event of the same kind arrives before software has cleared the first.

On a bus error it captures the faulting address. That capture stays frozen while the bus-error flag is set, so a later error never overwrites the details of the first one. Software reads the flags, clears them by writing ones, and gates the interrupt line with an enable bit in a small control register.

Register map (word offsets): control at 0x0 (bit 0 lock, bit 1 interrupt enable), status at 0x4 (write-one-to-clear), captured address at 0x8 (read-only). Any other aligned offset reads as zero, and writes to it are ignored.

Top module: `err_status_unit`

## Requirements
- R1: Status flags are sticky. Writing a 1 to a status bit at offset 0x4 clears that bit. Writing 0 leaves it unchanged.
- R2: The lock-write flag (status bit 17) is set by any read or write of the control register while the control lock bit (bit 0) and the external global-lock input are both 1. Such a write does not change the control register, and such a read returns 0.
- R3: The address flag (status bit 16) is set by any access whose address bits [1:0] are non-zero, or by a write to the read-only capture register (0x8). Neither kind of access changes any register, and an unaligned read returns 0.
- R4: A bus-error pulse sets the bus-error flag (bit 2). If that flag is already set when the pulse arrives, the bus-error overrun flag (bit 3) is also set.
- R5: The captured address loads the bus-error address only when a bus error arrives while the bus-error flag is clear. Otherwise it holds its value.
- R6: Every error event (bus error, lock-write error, address error) sets the interrupt-request flag (bit 0). An event that arrives while that flag is already set also sets the interrupt-overrun flag (bit 1).
- R7: When a clearing write and a setting event hit the same status bit in the same cycle, the bit ends up set.
- R8: The interrupt output is high exactly while the interrupt-request flag and the control interrupt-enable bit (bit 1) are both set.
- R9: After reset, every register reads 0. Status bits other than 0–3, 16 and 17 always read 0. Read data and its valid strobe appear one cycle after the read access.
- R10: Control bits 0 and 1 are writable at offset 0x0 when no lock is in force. Aligned accesses to unmapped offsets read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Register access strobe, one cycle per access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| acc_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read |
| rd_data_o | output | 32 | Read data |
| glock_i | input | 1 | External global-lock request |
| bus_err_i | input | 1 | Bus-error event pulse |
| bus_err_addr_i | input | CAP_W | Faulting address that comes with a bus error |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with its defaults, ADDR_W = 12 and CAP_W = 32. This puts the unmapped offsets and the unaligned addresses within a short address range, and lets full 32-bit captured addresses be compared directly. The 12-bit address makes it cheap to walk the mapped, unmapped and misaligned offsets. The full capture width shows that a second bus error leaves every captured bit untouched.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;

    localparam int NFLAG = 6;

    // compact flag indices
    localparam int F_IRQ   = 0;
    localparam int F_IOVR  = 1;
    localparam int F_BERR  = 2;
    localparam int F_BEOVR = 3;
    localparam int F_ADR   = 4;
    localparam int F_LW    = 5;

    // register offsets
    localparam int OFS_CTL  = 'h0;
    localparam int OFS_STAT = 'h4;
    localparam int OFS_CAP  = 'h8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTL  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CAP  = 2'd3
    } rd_sel_e;

    // position of a compact flag inside the 32-bit status word
    function automatic int flag_pos(input int idx);
        case (idx)
            F_IRQ:   return 0;
            F_IOVR:  return 1;
            F_BERR:  return 2;
            F_BEOVR: return 3;
            F_ADR:   return 16;
            default: return 17;
        endcase
    endfunction

endpackage

// File: rtl/err_acc_decode.sv
module err_acc_decode
    import err_stat_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              lock_bit,
    input  logic              glock,
    output logic              wr_ctl,
    output logic              wr_stat,
    output logic              rd_fire,
    output rd_sel_e           rd_sel,
    output logic              lw_evt,
    output logic              adr_evt
);

    logic aligned;
    logic is_ctl;
    logic is_stat;
    logic is_cap;
    logic locked;

    always_comb begin
        aligned = (acc_addr[1:0] == 2'b00);
        is_ctl  = aligned && (acc_addr == ADDR_W'(OFS_CTL));
        is_stat = aligned && (acc_addr == ADDR_W'(OFS_STAT));
        is_cap  = aligned && (acc_addr == ADDR_W'(OFS_CAP));
        locked  = lock_bit && glock;

        adr_evt = acc_valid && (!aligned || (acc_write && is_cap));
        lw_evt  = acc_valid && is_ctl && locked;
        wr_ctl  = acc_valid && acc_write && is_ctl && !locked;
        wr_stat = acc_valid && acc_write && is_stat;
        rd_fire = acc_valid && !acc_write;

        rd_sel = SEL_NONE;
        if (rd_fire) begin
            if (is_ctl && !locked) rd_sel = SEL_CTL;
            else if (is_stat)      rd_sel = SEL_STAT;
            else if (is_cap)       rd_sel = SEL_CAP;
        end
    end

endmodule

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
    parameter int NF = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_vec,
    input  logic [NF-1:0] clr_vec,
    output logic [NF-1:0] flags_q
);

    logic [NF-1:0] flags_d;

    for (genvar i = 0; i < NF; i++) begin : g_flag
        // a set in the same cycle as a clear keeps the bit set
        always_comb flags_d[i] = set_vec[i] | (flags_q[i] & ~clr_vec[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

endmodule

// File: rtl/err_cap_reg.sv
module err_cap_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] cap_q
);

    logic [W-1:0] cap_d;

    always_comb cap_d = load ? din : cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

endmodule

// File: rtl/err_status_unit.sv
module err_status_unit
    import err_stat_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CAP_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [31:0]       acc_wdata_i,
    output logic              rd_valid_o,
    output logic [31:0]       rd_data_o,
    input  logic              glock_i,
    input  logic              bus_err_i,
    input  logic [CAP_W-1:0]  bus_err_addr_i,
    output logic              irq_o
);

    typedef struct packed {
        logic        ctl_lock;
        logic        ctl_ie;
        logic        rd_valid;
        logic [31:0] rd_data;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic             wr_ctl, wr_stat, rd_fire, lw_evt, adr_evt;
    rd_sel_e          rd_sel;
    logic [NFLAG-1:0] set_vec, clr_vec, flags_q;
    logic [31:0]      status_word;
    logic [CAP_W-1:0] cap_q;
    logic [31:0]      cap_word;
    logic             evt_any;

    err_acc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .acc_valid (acc_valid_i),
        .acc_write (acc_write_i),
        .acc_addr  (acc_addr_i),
        .lock_bit  (st_q.ctl_lock),
        .glock     (glock_i),
        .wr_ctl    (wr_ctl),
        .wr_stat   (wr_stat),
        .rd_fire   (rd_fire),
        .rd_sel    (rd_sel),
        .lw_evt    (lw_evt),
        .adr_evt   (adr_evt)
    );

    always_comb begin
        evt_any          = bus_err_i | lw_evt | adr_evt;
        set_vec          = '0;
        set_vec[F_IRQ]   = evt_any;
        set_vec[F_IOVR]  = evt_any & flags_q[F_IRQ];
        set_vec[F_BERR]  = bus_err_i;
        set_vec[F_BEOVR] = bus_err_i & flags_q[F_BERR];
        set_vec[F_ADR]   = adr_evt;
        set_vec[F_LW]    = lw_evt;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_map
        always_comb clr_vec[i] = wr_stat & acc_wdata_i[flag_pos(i)];
    end

    always_comb begin
        status_word = '0;
        for (int i = 0; i < NFLAG; i++) status_word[flag_pos(i)] = flags_q[i];
    end

    err_flag_bank #(.NF(NFLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags_q (flags_q)
    );

    err_cap_reg #(.W(CAP_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bus_err_i & ~flags_q[F_BERR]),
        .din   (bus_err_addr_i),
        .cap_q (cap_q)
    );

    if (CAP_W >= 32) begin : g_cap_trunc
        assign cap_word = cap_q[31:0];
    end else begin : g_cap_pad
        assign cap_word = {{(32-CAP_W){1'b0}}, cap_q};
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = rd_fire;
        if (wr_ctl) begin
            st_d.ctl_lock = acc_wdata_i[0];
            st_d.ctl_ie   = acc_wdata_i[1];
        end
        if (rd_fire) begin
            case (rd_sel)
                SEL_CTL:  st_d.rd_data = {30'd0, st_q.ctl_ie, st_q.ctl_lock};
                SEL_STAT: st_d.rd_data = status_word;
                SEL_CAP:  st_d.rd_data = cap_word;
                default:  st_d.rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid_o = st_q.rd_valid;
    assign rd_data_o  = st_q.rd_data;
    assign irq_o      = flags_q[F_IRQ] & st_q.ctl_ie;

endmodule

// File: rtl/err_status_unit_chk.sv
module err_status_unit_chk #(
    parameter int ADDR_W = 12,
    parameter int CAP_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [31:0]       acc_wdata,
    input logic              glock,
    input logic              bus_err,
    input logic              irq,
    input logic [31:0]       status,
    input logic [CAP_W-1:0]  cap,
    input logic              ctl_lock,
    input logic              ctl_ie
);

    logic clr_stat_berr, clr_stat_irq;
    assign clr_stat_berr = acc_valid && acc_write && (acc_addr == ADDR_W'(4)) && acc_wdata[2];
    assign clr_stat_irq  = acc_valid && acc_write && (acc_addr == ADDR_W'(4)) && acc_wdata[0];

    p_lw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && ctl_lock && glock && acc_addr == ADDR_W'(0)) |=> status[17]);

    p_lw_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_lock && glock) |=> $stable(ctl_lock) && $stable(ctl_ie));

    p_adr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[1:0] != 2'b00) |=> status[16]);

    p_berr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> status[2]);

    p_beovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && status[2]) |=> status[3]);

    p_berr_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !clr_stat_berr) |=> status[2]);

    p_cap_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |=> $stable(cap));

    p_irq_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && ctl_ie && !(acc_valid && acc_write && acc_addr == ADDR_W'(0))) |=> irq);

    p_irq_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !clr_stat_irq) |=> status[0]);

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~32'h0003_000F) == 32'd0);

endmodule

bind err_status_unit err_status_unit_chk #(.ADDR_W(ADDR_W), .CAP_W(CAP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid_i),
    .acc_write (acc_write_i),
    .acc_addr  (acc_addr_i),
    .acc_wdata (acc_wdata_i),
    .glock     (glock_i),
    .bus_err   (bus_err_i),
    .irq       (irq_o),
    .status    (status_word),
    .cap       (cap_q),
    .ctl_lock  (st_q.ctl_lock),
    .ctl_ie    (st_q.ctl_ie)
);

// File: tb/err_status_unit_test.sv
module err_status_unit_test;

    localparam int AW = 12;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [31:0]   acc_wdata = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          glock = 1'b0;
    logic          bus_err = 1'b0;
    logic [CW-1:0] bus_err_addr = '0;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    err_status_unit #(.ADDR_W(AW), .CAP_W(CW)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .acc_valid_i    (acc_valid),
        .acc_write_i    (acc_write),
        .acc_addr_i     (acc_addr),
        .acc_wdata_i    (acc_wdata),
        .rd_valid_o     (rd_valid),
        .rd_data_o      (rd_data),
        .glock_i        (glock),
        .bus_err_i      (bus_err),
        .bus_err_addr_i (bus_err_addr),
        .irq_o          (irq)
    );

    // monitor: pop expected read data when the design returns it
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected read data %08h", rd_data);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL %s read got %08h expected %08h", t, rd_data, e);
                end
            end
        end
    end

    // one-cycle access, optionally with a simultaneous bus error
    task automatic cycle(input logic v, input logic wr, input logic [AW-1:0] a,
                         input logic [31:0] d, input logic be, input logic [CW-1:0] ba,
                         input logic [31:0] exp, input string tag);
        @(negedge clk);
        acc_valid = v; acc_write = wr; acc_addr = a; acc_wdata = d;
        bus_err = be; bus_err_addr = ba;
        if (v && !wr) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; bus_err = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        cycle(1'b1, 1'b0, a, 32'd0, 1'b0, '0, exp, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        cycle(1'b1, 1'b1, a, d, 1'b0, '0, 32'd0, "");
    endtask

    task automatic berr(input logic [CW-1:0] ba);
        cycle(1'b0, 1'b0, '0, 32'd0, 1'b1, ba, 32'd0, "");
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        n_tests++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s irq_o got %0b expected %0b", tag, irq, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        chk_irq(1'b0, "R9 reset");
        rd(12'h4, 32'h0, "R9 status reset");
        rd(12'h0, 32'h0, "R9 ctl reset");
        rd(12'h8, 32'h0, "R9 cap reset");

        // R10 control write
        wr(12'h0, 32'hFFFF_FFFE);
        rd(12'h0, 32'h2, "R10 ctl ie only");

        // R4 R6 R5 R8 first bus error
        berr(32'h0000_1234);
        chk_irq(1'b1, "R8 irq after bus error");
        rd(12'h4, 32'h5, "R4 R6 berr+irq");
        rd(12'h8, 32'h0000_1234, "R5 capture");

        // second bus error: overruns, capture frozen
        berr(32'h0000_5678);
        rd(12'h4, 32'hF, "R4 R6 overruns");
        rd(12'h8, 32'h0000_1234, "R5 capture frozen");

        // R1 write zero no effect, then clear BERR only
        wr(12'h4, 32'h0);
        rd(12'h4, 32'hF, "R1 write 0 no effect");
        wr(12'h4, 32'h4);
        rd(12'h4, 32'hB, "R1 clear berr");
        berr(32'h0000_9ABC);
        rd(12'h8, 32'h0000_9ABC, "R5 capture after clear");
        rd(12'h4, 32'hF, "R4 berr again");

        // clear all
        wr(12'h4, 32'hFFFF_FFFF);
        rd(12'h4, 32'h0, "R1 clear all");
        chk_irq(1'b0, "R8 irq low after clear");

        // R3 unaligned read, read-only write, unaligned write
        rd(12'h5, 32'h0, "R3 unaligned read data");
        rd(12'h4, 32'h0001_0001, "R3 adrerr set");
        wr(12'h8, 32'hDEAD_BEEF);
        rd(12'h8, 32'h0000_9ABC, "R3 cap not written");
        wr(12'h1, 32'h0);
        rd(12'h0, 32'h2, "R3 ctl unchanged by unaligned write");
        rd(12'h4, 32'h0001_0003, "R3 R6 adrerr iovr");
        wr(12'h4, 32'h0003_000F);

        // R10 unmapped offset
        wr(12'hC, 32'hFFFF_FFFF);
        rd(12'hC, 32'h0, "R10 unmapped reads 0");
        rd(12'h4, 32'h0, "R10 unmapped no error");

        // R2 lock
        wr(12'h0, 32'h3);
        rd(12'h0, 32'h3, "R2 no global lock readable");
        glock = 1'b1;
        wr(12'h0, 32'h0);
        rd(12'h4, 32'h0002_0001, "R2 lwerr on write");
        rd(12'h0, 32'h0, "R2 locked read returns 0");
        rd(12'h4, 32'h0002_0003, "R2 lwerr on read");
        glock = 1'b0;
        rd(12'h0, 32'h3, "R2 ctl kept through lock");
        wr(12'h0, 32'h2);
        wr(12'h4, 32'h0003_000F);
        rd(12'h4, 32'h0, "R2 cleared");

        // R7 set wins over clear
        berr(32'h0000_0040);
        cycle(1'b1, 1'b1, 12'h4, 32'h5, 1'b1, 32'h80, 32'd0, "");
        rd(12'h4, 32'hF, "R7 set wins");

        // R8 enable gate
        wr(12'h0, 32'h0);
        chk_irq(1'b0, "R8 irq masked");
        wr(12'h0, 32'h2);
        chk_irq(1'b1, "R8 irq unmasked");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL R9 missing read data: %0d outstanding, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule